// File: doc/BRIEF.md
# Dual-Buffer Ethernet Transmit Controller

This block stores outgoing Ethernet frames in one or two word-addressed transmit buffers and streams them out one byte at a time to a MAC transmit path. Software loads a frame into a buffer over a 32-bit word bus and writes the frame length. It then sets the buffer's busy flag. The block sends exactly that many bytes through a valid/ready byte interface and clears the flag when the last byte has been accepted. Preamble and FCS are added further down the path, not here.

The same buffer can also carry the station address. When the busy and load-address flags are set together, the block copies the first six buffer bytes into its station address register and sends nothing. Each buffer has its own completion flag and interrupt enable, and the interrupt output is the OR of every buffer that has both set. A parameter chooses whether the second buffer exists. When it does not, that half of the map reads as zero and ignores writes.

Top module: `dbtx_ctrl`

## Requirements
- R1: After reset every length and status register reads 0, `tx_valid_o` and `irq_o` are low, and `mac_addr_o` is 0.
- R2: Setting status bit 0 (busy) of a buffer emits exactly length bytes. Byte k is bits [8*(k mod 4)+7 : 8*(k mod 4)] of buffer word k/4 (little-endian). Busy then reads 0.
- R3: The length register keeps only write-data bits 15:0. Bits 31:16 are ignored and read back as 0.
- R4: Writing 0x3 to a status register (bits 0 and 1) emits no bytes and loads `mac_addr_o[8k+7:8k]` with buffer byte k for k = 0..5. Bits 0 and 1 then read 0.
- R5: Finishing a send or an address load sets status bit 2 (complete). `irq_o` is high while any buffer has bit 2 and bit 3 (interrupt enable) both set. Any write to a status register clears that buffer's bit 2.
- R6: Writing 0 to a status register stops that buffer at once. `tx_valid_o` is low from the next cycle, no further bytes of that frame are sent, and bit 2 stays 0.
- R7: When the second buffer becomes busy while the first is still in service, the second is sent after the first. Its first byte is offered in the cycle right after the first frame's last byte is accepted.
- R8: With HAS_SECOND = 0, addresses 0x800 to 0xFFC read 0 and writes there have no effect; in particular, no frame is sent.
- R9: The primary buffer data starts at byte address 0x000, with length at 0x7F4 and status at 0x7FC. The secondary buffer data starts at 0x800, with length at 0xFF4 and status at 0xFFC. Buffer words read back one cycle after `bus_re_i`, like all reads.
- R10: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_data_o` holds its value.
- R11: A frame of length 0 completes without offering any byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Word write strobe |
| bus_re_i | input | 1 | Word read strobe |
| bus_addr_i | input | ADDR_W | Byte address of the word |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid one cycle after the read strobe |
| tx_data_o | output | 8 | Frame byte toward the MAC |
| tx_valid_o | output | 1 | Byte is offered |
| tx_ready_i | input | 1 | MAC accepts the byte |
| mac_addr_o | output | 48 | Station address, byte 0 in bits 7:0 |
| irq_o | output | 1 | Completion interrupt level |

## Verification
The bench throttles `tx_ready_i` to catch data that changes during a stall, and a design that advanced on valid alone would drop or repeat bytes. It queues the second buffer behind a stalled first one and checks that the hand-over leaves no idle cycle and does not reorder the two frames. Aborts, zero-length frames and address loads are each checked to produce no bytes, since a design that ignored the abort or the load flag would stream the buffer anyway. A second copy built without the secondary buffer must read zeros and stay silent after a start command in that region.

// File: rtl/dbtx_pkg.sv
`timescale 1ns/1ps
package dbtx_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_SEND, ST_PROG0, ST_PROG1, ST_FIN} eng_st_e;
  localparam int BUSY_B    = 0;
  localparam int PROG_B    = 1;
  localparam int CMPL_B    = 2;
  localparam int IE_B      = 3;
  localparam int MAC_BYTES = 6;
endpackage

// File: rtl/dbtx_buf_ram.sv
`timescale 1ns/1ps
module dbtx_buf_ram #(
  parameter int WORD_AW = 9,
  parameter int DATA_W  = 32
) (
  input  logic               clk_i,
  input  logic               we_i,
  input  logic [WORD_AW-1:0] waddr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [WORD_AW-1:0] a_addr_i,
  output logic [DATA_W-1:0]  a_data_o,
  input  logic [WORD_AW-1:0] b_addr_i,
  output logic [DATA_W-1:0]  b_data_o
);
  localparam int DEPTH = 1 << WORD_AW;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign a_data_o = mem[a_addr_i];
  assign b_data_o = mem[b_addr_i];
endmodule

// File: rtl/dbtx_slot_regs.sv
`timescale 1ns/1ps
module dbtx_slot_regs import dbtx_pkg::*; #(
  parameter int LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             len_we_i,
  input  logic [LEN_W-1:0] len_wdata_i,
  input  logic             stat_we_i,
  input  logic [IE_B:0]    stat_wdata_i,
  input  logic             done_i,
  output logic             busy_o,
  output logic             prog_o,
  output logic             ie_o,
  output logic             cmpl_o,
  output logic [LEN_W-1:0] len_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      prog_o <= 1'b0;
      ie_o   <= 1'b0;
      cmpl_o <= 1'b0;
      len_o  <= '0;
    end else begin
      if (len_we_i) len_o <= len_wdata_i;
      // a software write takes priority over a completion in the same cycle
      if (stat_we_i) begin
        busy_o <= stat_wdata_i[BUSY_B];
        prog_o <= stat_wdata_i[PROG_B];
        ie_o   <= stat_wdata_i[IE_B];
        cmpl_o <= 1'b0;
      end else if (done_i) begin
        busy_o <= 1'b0;
        prog_o <= 1'b0;
        cmpl_o <= 1'b1;
      end
    end
  end

  a_r2_done_clears_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !stat_we_i) |=> (!busy_o && cmpl_o));

  a_r5_write_clears_cmpl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_we_i |=> !cmpl_o);
endmodule

// File: rtl/dbtx_engine.sv
`timescale 1ns/1ps
module dbtx_engine import dbtx_pkg::*; #(
  parameter int LEN_W   = 16,
  parameter int WORD_AW = 9,
  parameter int DATA_W  = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [1:0]            busy_i,
  input  logic [1:0]            prog_i,
  input  logic [1:0][LEN_W-1:0] len_i,
  input  logic [DATA_W-1:0]     word_i,
  output logic [WORD_AW-1:0]    rd_addr_o,
  output logic                  rd_slot_o,
  output logic [7:0]            tx_data_o,
  output logic                  tx_valid_o,
  input  logic                  tx_ready_i,
  output logic [1:0]            done_o,
  output logic [8*MAC_BYTES-1:0] mac_addr_o
);
  localparam int MAC_W = 8 * MAC_BYTES;

  eng_st_e           st_q, st_d;
  logic              cur_q, cur_d;
  logic [LEN_W-1:0]  idx_q, idx_d;
  logic [MAC_W-1:0]  mac_q, mac_d;
  logic [DATA_W-1:0] lo_q, lo_d;

  logic       cur_live, fire, last, finish, launch, pick;
  logic [1:0] avail;

  assign cur_live   = busy_i[cur_q];
  assign tx_valid_o = (st_q == ST_SEND) && cur_live;
  assign fire       = tx_valid_o && tx_ready_i;
  assign last       = idx_q == (len_i[cur_q] - LEN_W'(1));
  assign finish     = cur_live && ((st_q == ST_SEND && fire && last) ||
                                   st_q == ST_PROG1 || st_q == ST_FIN);
  assign done_o     = finish ? (2'b01 << cur_q) : 2'b00;
  assign avail      = busy_i & ~done_o;
  // the slot in service is excluded, so the waiting one is taken next
  assign pick       = avail[0] ? 1'b0 : 1'b1;
  assign launch     = (st_q == ST_IDLE) || finish;

  assign rd_slot_o  = cur_q;
  assign tx_data_o  = word_i[{idx_q[1:0], 3'b000} +: 8];
  assign mac_addr_o = mac_q;

  always_comb begin
    case (st_q)
      ST_PROG0: rd_addr_o = '0;
      ST_PROG1: rd_addr_o = WORD_AW'(1);
      default:  rd_addr_o = idx_q[WORD_AW+1:2];
    endcase
  end

  always_comb begin
    st_d  = st_q;
    cur_d = cur_q;
    idx_d = idx_q;
    mac_d = mac_q;
    lo_d  = lo_q;
    if (st_q == ST_PROG1 && cur_live) mac_d = {word_i[MAC_W-DATA_W-1:0], lo_q};
    if (st_q != ST_IDLE && !cur_live) begin
      st_d = ST_IDLE;
    end else if (launch) begin
      if (|avail) begin
        cur_d = pick;
        idx_d = '0;
        if (prog_i[pick])            st_d = ST_PROG0;
        else if (len_i[pick] == '0)  st_d = ST_FIN;
        else                         st_d = ST_SEND;
      end else begin
        st_d = ST_IDLE;
      end
    end else begin
      case (st_q)
        ST_SEND: if (fire) idx_d = idx_q + LEN_W'(1);
        ST_PROG0: begin
          lo_d = word_i;
          st_d = ST_PROG1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cur_q <= 1'b0;
      idx_q <= '0;
      mac_q <= '0;
      lo_q  <= '0;
    end else begin
      st_q  <= st_d;
      cur_q <= cur_d;
      idx_q <= idx_d;
      mac_q <= mac_d;
      lo_q  <= lo_d;
    end
  end

  a_r10_hold_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> (!tx_valid_o || $stable(tx_data_o)));

  a_r4_prog_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PROG0) |=> !fire);
endmodule

// File: rtl/dbtx_ctrl.sv
`timescale 1ns/1ps
module dbtx_ctrl import dbtx_pkg::*; #(
  parameter int ADDR_W     = 12,
  parameter int LEN_W      = 16,
  parameter bit HAS_SECOND = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic [7:0]        tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic [47:0]       mac_addr_o,
  output logic              irq_o
);
  localparam int DATA_W     = 32;
  localparam int NSLOT      = 2;
  localparam int SLOT_AW    = ADDR_W - 1;
  localparam int SLOT_BYTES = 1 << SLOT_AW;
  localparam int WORD_AW    = SLOT_AW - 2;
  localparam int LEN_OFS    = SLOT_BYTES - 12;
  localparam int STAT_OFS   = SLOT_BYTES - 4;

  logic               slot_sel, is_len, is_stat, is_buf;
  logic [SLOT_AW-1:0] ofs;
  logic [WORD_AW-1:0] bus_word_addr, eng_addr;
  logic               eng_slot;

  assign slot_sel      = bus_addr_i[ADDR_W-1];
  assign ofs           = bus_addr_i[SLOT_AW-1:0];
  assign is_len        = ofs == SLOT_AW'(LEN_OFS);
  assign is_stat       = ofs == SLOT_AW'(STAT_OFS);
  assign is_buf        = ofs <  SLOT_AW'(LEN_OFS);
  assign bus_word_addr = ofs[SLOT_AW-1:2];

  logic [NSLOT-1:0]             busy, prog, ie, cmpl, done;
  logic [NSLOT-1:0][LEN_W-1:0]  len;
  logic [NSLOT-1:0][DATA_W-1:0] bus_word, eng_word;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    if (s == 0 || HAS_SECOND) begin : g_on
      logic hit;
      assign hit = bus_we_i && (slot_sel == 1'(s));

      dbtx_buf_ram #(.WORD_AW(WORD_AW), .DATA_W(DATA_W)) u_ram (
        .clk_i    (clk_i),
        .we_i     (hit && is_buf),
        .waddr_i  (bus_word_addr),
        .wdata_i  (bus_wdata_i),
        .a_addr_i (bus_word_addr),
        .a_data_o (bus_word[s]),
        .b_addr_i (eng_addr),
        .b_data_o (eng_word[s])
      );

      dbtx_slot_regs #(.LEN_W(LEN_W)) u_regs (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .len_we_i     (hit && is_len),
        .len_wdata_i  (bus_wdata_i[LEN_W-1:0]),
        .stat_we_i    (hit && is_stat),
        .stat_wdata_i (bus_wdata_i[IE_B:0]),
        .done_i       (done[s]),
        .busy_o       (busy[s]),
        .prog_o       (prog[s]),
        .ie_o         (ie[s]),
        .cmpl_o       (cmpl[s]),
        .len_o        (len[s])
      );
    end else begin : g_off
      assign busy[s]     = 1'b0;
      assign prog[s]     = 1'b0;
      assign ie[s]       = 1'b0;
      assign cmpl[s]     = 1'b0;
      assign len[s]      = '0;
      assign bus_word[s] = '0;
      assign eng_word[s] = '0;
    end
  end

  dbtx_engine #(.LEN_W(LEN_W), .WORD_AW(WORD_AW), .DATA_W(DATA_W)) u_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .busy_i     (busy),
    .prog_i     (prog),
    .len_i      (len),
    .word_i     (eng_word[eng_slot]),
    .rd_addr_o  (eng_addr),
    .rd_slot_o  (eng_slot),
    .tx_data_o  (tx_data_o),
    .tx_valid_o (tx_valid_o),
    .tx_ready_i (tx_ready_i),
    .done_o     (done),
    .mac_addr_o (mac_addr_o)
  );

  assign irq_o = |(ie & cmpl);

  logic [DATA_W-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    if (is_stat) begin
      rd_next[BUSY_B] = busy[slot_sel];
      rd_next[PROG_B] = prog[slot_sel];
      rd_next[CMPL_B] = cmpl[slot_sel];
      rd_next[IE_B]   = ie[slot_sel];
    end else if (is_len) begin
      rd_next[LEN_W-1:0] = len[slot_sel];
    end else if (is_buf) begin
      rd_next = bus_word[slot_sel];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       bus_rdata_o <= '0;
    else if (bus_re_i) bus_rdata_o <= rd_next;
  end

  a_r6_zero_write_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && is_stat && !slot_sel && bus_wdata_i[IE_B:0] == '0)
      |=> (!busy[0] && !cmpl[0]));
endmodule

// File: tb/dbtx_ctrl_bench.sv
`timescale 1ns/1ps
module dbtx_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, re = 1'b0, ready = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata_s;
  logic [7:0]  tx_data, tx_data_s;
  logic        tx_valid, tx_valid_s, irq, irq_s;
  logic [47:0] mac, mac_s;

  int checks = 0, errors = 0, cyc = 0, ready_mode = 2;
  int hold_err = 0;
  bit s_seen = 1'b0, prev_stall = 1'b0;
  logic [7:0] prev_data = '0;
  logic [7:0] cap[$];
  int         cap_cyc[$];
  logic [7:0] exp_q[$];

  always #10 clk = ~clk;

  dbtx_ctrl u_dbtx_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_re_i(re), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .tx_data_o(tx_data),
    .tx_valid_o(tx_valid), .tx_ready_i(ready), .mac_addr_o(mac), .irq_o(irq));

  dbtx_ctrl #(.HAS_SECOND(1'b0)) u_dbtx_ctrl_single (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_re_i(re), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata_s), .tx_data_o(tx_data_s),
    .tx_valid_o(tx_valid_s), .tx_ready_i(ready), .mac_addr_o(mac_s), .irq_o(irq_s));

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    case (ready_mode)
      0:       ready <= 1'b1;
      1:       ready <= (cyc % 3) != 1;
      default: ready <= 1'b0;
    endcase
  end

  always @(negedge clk) begin
    #5;
    if (tx_valid && ready) begin
      cap.push_back(tx_data);
      cap_cyc.push_back(cyc);
    end
    if (prev_stall && tx_valid && tx_data != prev_data) hold_err++;
    prev_stall = tx_valid && !ready;
    prev_data  = tx_data;
    if (tx_valid_s) s_seen = 1'b1;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bw(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic br(input logic [11:0] a, output logic [31:0] d, output logic [31:0] ds);
    @(negedge clk);
    re = 1'b1; addr = a;
    @(negedge clk);
    re = 1'b0;
    d = rdata; ds = rdata_s;
  endtask

  task automatic fill(input logic [11:0] base, input int n, input int seed);
    exp_q.delete();
    for (int w = 0; w < (n + 3) / 4; w++) begin
      logic [31:0] word = '0;
      for (int b = 0; b < 4; b++) begin
        int k = w * 4 + b;
        if (k < n) begin
          logic [7:0] v = 8'(seed + k * 13);
          word[8*b +: 8] = v;
          exp_q.push_back(v);
        end
      end
      bw(base + 12'(w * 4), word);
    end
  endtask

  task automatic wait_idle(input logic [11:0] a);
    logic [31:0] d, ds;
    for (int i = 0; i < 500; i++) begin
      br(a, d, ds);
      if (!d[0]) break;
    end
  endtask

  task automatic cmp_frame(input string tag);
    int bad = 0;
    chk({tag, " byte count"}, 64'(cap.size()), 64'(exp_q.size()));
    for (int i = 0; i < exp_q.size() && i < cap.size(); i++)
      if (cap[i] !== exp_q[i]) bad++;
    chk({tag, " byte mismatches"}, 64'(bad), 0);
  endtask

  task automatic clear_cap();
    cap.delete();
    cap_cyc.delete();
  endtask

  task automatic t_reset();
    logic [31:0] d, ds;
    chk("R1 tx_valid", 64'(tx_valid), 0);
    chk("R1 irq", 64'(irq), 0);
    chk("R1 mac", 64'(mac), 0);
    br(12'h7FC, d, ds); chk("R1 status", 64'(d), 0);
    br(12'hFF4, d, ds); chk("R1 length", 64'(d), 0);
  endtask

  task automatic t_map();
    logic [31:0] d, ds;
    bw(12'h004, 32'hDEADBEEF);
    bw(12'h808, 32'h01234567);
    br(12'h004, d, ds); chk("R9 primary word", 64'(d), 64'hDEADBEEF);
    br(12'h808, d, ds); chk("R9 secondary word", 64'(d), 64'h01234567);
    bw(12'h7F4, 32'hABCD1234);
    br(12'h7F4, d, ds); chk("R3 length upper ignored", 64'(d), 64'h1234);
  endtask

  task automatic t_single_frame();
    logic [31:0] d, ds;
    ready_mode = 0;
    fill(12'h000, 10, 5);
    bw(12'h7F4, 10);
    clear_cap();
    bw(12'h7FC, 32'h1);
    wait_idle(12'h7FC);
    cmp_frame("R2 primary frame");
    br(12'h7FC, d, ds); chk("R2 busy clear, R5 complete set", 64'(d), 64'h4);
    chk("R5 irq off without enable", 64'(irq), 0);
  endtask

  task automatic t_throttle();
    ready_mode = 1;
    hold_err = 0;
    fill(12'h800, 7, 8'h40);
    bw(12'hFF4, 7);
    clear_cap();
    bw(12'hFFC, 32'h1);
    wait_idle(12'hFFC);
    cmp_frame("R2 secondary throttled frame");
    chk("R10 data held during stall", 64'(hold_err), 0);
    ready_mode = 0;
  endtask

  task automatic t_prog();
    logic [31:0] d, ds;
    bw(12'h000, 32'h44332211);
    bw(12'h004, 32'h00006655);
    clear_cap();
    bw(12'h7FC, 32'h3);
    wait_idle(12'h7FC);
    repeat (3) @(negedge clk);
    chk("R4 station address", 64'(mac), 64'h665544332211);
    chk("R4 no bytes sent", 64'(cap.size()), 0);
    br(12'h7FC, d, ds); chk("R4 flags cleared", 64'(d[1:0]), 0);
  endtask

  task automatic t_irq();
    logic [31:0] d, ds;
    fill(12'h000, 4, 9);
    bw(12'h7F4, 4);
    bw(12'h7FC, 32'h9);
    wait_idle(12'h7FC);
    chk("R5 irq raised", 64'(irq), 1);
    br(12'h7FC, d, ds); chk("R5 status enable+complete", 64'(d), 64'hC);
    bw(12'h7FC, 32'h0);
    chk("R5 irq cleared by write", 64'(irq), 0);
  endtask

  task automatic t_abort();
    logic [31:0] d, ds;
    ready_mode = 2;
    fill(12'h000, 20, 3);
    bw(12'h7F4, 20);
    clear_cap();
    bw(12'h7FC, 32'h1);
    repeat (5) @(negedge clk);
    chk("R6 frame offered before abort", 64'(tx_valid), 1);
    bw(12'h7FC, 32'h0);
    chk("R6 valid drops after abort", 64'(tx_valid), 0);
    ready_mode = 0;
    repeat (30) @(negedge clk);
    chk("R6 no bytes after abort", 64'(cap.size()), 0);
    br(12'h7FC, d, ds); chk("R6 status idle, no complete", 64'(d), 0);
  endtask

  task automatic t_order();
    logic [7:0] both[$];
    ready_mode = 2;
    fill(12'h800, 5, 8'h80);
    both = exp_q;
    bw(12'hFF4, 5);
    fill(12'h000, 3, 8'h10);
    foreach (exp_q[i]) both.push_back(exp_q[i]);
    exp_q = both;
    bw(12'h7F4, 3);
    bw(12'hFFC, 32'h1);
    bw(12'h7FC, 32'h1);
    clear_cap();
    ready_mode = 0;
    wait_idle(12'hFFC);
    wait_idle(12'h7FC);
    cmp_frame("R7 secondary then primary");
    if (cap_cyc.size() == 8)
      chk("R7 no gap between frames", 64'(cap_cyc[5] - cap_cyc[4]), 1);
    else
      chk("R7 capture size for gap check", 64'(cap_cyc.size()), 8);
  endtask

  task automatic t_zero_len();
    logic [31:0] d, ds;
    bw(12'h7F4, 32'hFFFF0000);
    clear_cap();
    bw(12'h7FC, 32'h1);
    wait_idle(12'h7FC);
    repeat (5) @(negedge clk);
    chk("R11 zero-length sends nothing", 64'(cap.size()), 0);
    br(12'h7FC, d, ds); chk("R11 zero-length completes", 64'(d), 64'h4);
  endtask

  task automatic t_no_second();
    logic [31:0] d, ds;
    s_seen = 1'b0;
    bw(12'h800, 32'hCAFEF00D);
    bw(12'hFF4, 5);
    bw(12'hFFC, 32'h1);
    br(12'h800, d, ds); chk("R8 data region reads zero", 64'(ds), 0);
    br(12'hFF4, d, ds); chk("R8 length reads zero", 64'(ds), 0);
    br(12'hFFC, d, ds); chk("R8 status reads zero", 64'(ds), 0);
    repeat (20) @(negedge clk);
    chk("R8 no frame sent", 64'(s_seen), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_single_frame();
    t_throttle();
    t_prog();
    t_irq();
    t_abort();
    t_order();
    t_zero_len();
    t_no_second();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule